// File: doc/BRIEF.md
# System Clock Source Switch and Prescaler

This block produces the system clock. Six oscillator sources arrive as free-running clock inputs, each with its own ready input. A control register, written from the control clock domain, holds four things: a 3-bit source code, a 3-bit power-of-two prescale, an enable bit for each source, and a mode bit for a secondary clock that feeds a crypto engine. The block moves the system clock onto the selected source only once that source is both enabled and reporting ready. Until then the previous source keeps running.

The switch is glitch-free. Each source has a gate that opens and closes only while that source's clock is low. A request and acknowledge handshake ensures the old gate is seen closed before the new gate is asked to open. A divider after the source mux applies the prescale. A new prescale takes effect only when the current divided period ends. A read-only switch-ready flag tells software whether the system clock is running from the requested source. Synchronized copies of the six ready inputs are readable as status.

Top module: `sysclk_switch`

## Requirements
- R1: While reset is held and right after it, `sel_code` reads 0, `prescale` reads 0, `cdiv` reads 0, `osc_en` reads 6'b000001 and `sw_ready` reads 0. `sys_clk` has no edges until the selected source is ready.
- R2: A write (`cfg_we` high at a `ctl_clk` rising edge) with `cfg_src` equal to 1 or 7 leaves `sel_code` unchanged. The other fields of that same write are still loaded. All fields read back one `ctl_clk` cycle after the write edge.
- R3: A switch to a source whose `osc_en` bit is 0 or whose `osc_rdy` input is low does not happen. `sw_ready` stays 0, and `sys_clk` keeps the period of the previous source and prescale.
- R4: `sw_ready` reads 0 in the cycle after a new legal source code is loaded. It reads 1 within 400 `ctl_clk` cycles once the target source is enabled and ready.
- R5: After a switch completes, the `sys_clk` period equals the selected source period times 2^`prescale`. The source codes map as follows: 0 selects `src_clk[0]`, 2 selects `src_clk[1]`, 3 selects `src_clk[2]`, 4 selects `src_clk[3]`, 5 selects `src_clk[4]`, and 6 selects `src_clk[5]`.
- R6: A prescale change takes effect only at the end of a divided period. Every `sys_clk` high or low phase across the change has either the old phase length or the new one.
- R7: With `cdiv` at 0, `crypto_clk` follows `sys_clk`. With `cdiv` at 1, its period is twice the `sys_clk` period. A mode change is applied only at a rising edge of `sys_clk`.
- R8: `osc_rdy_stat[i]` equals the value `osc_rdy[i]` had two `ctl_clk` rising edges earlier.
- R9: Across every source switch and prescale change, no `sys_clk` or `crypto_clk` phase is shorter than half the period of the fastest source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control register clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| src_clk | input | 6 | Oscillator source clocks, one per source slot |
| osc_rdy | input | 6 | Per-source oscillator ready inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_src | input | 3 | Source code to write |
| cfg_prescale | input | 3 | Prescale exponent to write |
| cfg_cdiv | input | 1 | Crypto clock mode to write (1 = halved) |
| cfg_osc_en | input | 6 | Per-source enable bits to write |
| sel_code | output | 3 | Current source code |
| prescale | output | 3 | Current prescale exponent |
| cdiv | output | 1 | Current crypto clock mode |
| osc_en | output | 6 | Current enable bits |
| osc_rdy_stat | output | 6 | Synchronized ready status per source |
| sw_ready | output | 1 | 1 when the system clock runs from the selected source |
| sys_clk | output | 1 | System clock |
| crypto_clk | output | 1 | Crypto engine clock |

## Verification
Register fields are due one `ctl_clk` cycle after the write edge, and ready status is due two edges after the input changes. A behavioural model in the bench advances on each rising edge, and its outputs are compared at every falling edge, so both timings are checked exactly. `sw_ready` is checked as low at the first falling edge after a new code is loaded. Because its rise depends on synchronizers in several unrelated clock domains, it is polled against a 400-cycle bound rather than an exact cycle. Clock periods are measured between two rising edges only after a settle time that is longer than the slowest divided period. Phase lengths are checked at every `sys_clk` and `crypto_clk` edge.

// File: rtl/sysclk_switch_pkg.sv
`timescale 1ns/1ps
package sysclk_switch_pkg;
    localparam int NSRC = 6;
    localparam int SELW = 3;
    localparam int PREW = 3;
    localparam int IDXW = $clog2(NSRC);

    typedef logic [IDXW-1:0] idx_t;

    // legal codes: 0 and 2..NSRC; code 1 and anything above NSRC are unassigned
    function automatic logic code_legal(input logic [SELW-1:0] code);
        return (code != SELW'(1)) && (code <= SELW'(NSRC));
    endfunction

    function automatic idx_t code_to_idx(input logic [SELW-1:0] code);
        return (code == '0) ? '0 : IDXW'(code - SELW'(1));
    endfunction

    function automatic logic [NSRC-1:0] idx_onehot(input idx_t idx);
        return NSRC'(1) << idx;
    endfunction

    typedef struct packed {
        logic [SELW-1:0] sel;
        logic [PREW-1:0] pre;
        logic            cdiv;
        logic [NSRC-1:0] en;
        idx_t            act;
        logic            act_vld;
        logic [NSRC-1:0] rdy_s1;
        logic [NSRC-1:0] rdy_s2;
        logic [NSRC-1:0] ack_s1;
        logic [NSRC-1:0] ack_s2;
    } ctl_state_t;
endpackage

// File: rtl/sysclk_switch_ctrl.sv
`timescale 1ns/1ps
module sysclk_switch_ctrl
    import sysclk_switch_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_src,
    input  logic [PREW-1:0] cfg_pre,
    input  logic            cfg_cdiv,
    input  logic [NSRC-1:0] cfg_en,
    input  logic [NSRC-1:0] osc_rdy,
    input  logic [NSRC-1:0] gate_ack,
    output logic [SELW-1:0] sel_code,
    output logic [PREW-1:0] pre,
    output logic            cdiv,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] rdy_stat,
    output logic            sw_ready,
    output logic [NSRC-1:0] gate_req
);
    ctl_state_t d, q;
    idx_t       tgt;
    logic [NSRC-1:0] en_rdy;

    always_comb begin
        d        = q;
        tgt      = code_to_idx(q.sel);
        d.rdy_s1 = osc_rdy;
        d.rdy_s2 = q.rdy_s1;
        d.ack_s1 = gate_ack;
        d.ack_s2 = q.ack_s1;
        if (cfg_we) begin
            if (code_legal(cfg_src)) begin
                d.sel = cfg_src;
            end
            d.pre  = cfg_pre;
            d.cdiv = cfg_cdiv;
            d.en   = cfg_en;
        end
        // retarget the mux only when the requested source can run
        if ((!q.act_vld || q.act != tgt) && q.en[tgt] && q.rdy_s2[tgt]) begin
            d.act     = tgt;
            d.act_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.en  <= NSRC'(1);
        end else begin
            q <= d;
        end
    end

    // a gate may open only once every other gate is seen closed
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            gate_req[i] = q.act_vld && (q.act == IDXW'(i)) &&
                          ((q.ack_s2 & ~idx_onehot(IDXW'(i))) == '0);
        end
    end

    assign en_rdy   = q.en & q.rdy_s2;
    assign sw_ready = q.act_vld && (q.act == tgt) && (q.ack_s2 == idx_onehot(q.act));
    assign sel_code = q.sel;
    assign pre      = q.pre;
    assign cdiv     = q.cdiv;
    assign en       = q.en;
    assign rdy_stat = q.rdy_s2;

    assert_illegal_code_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !code_legal(cfg_src)) |=> $stable(q.sel));

    assert_switch_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act_vld && (!$past(q.act_vld) || q.act != $past(q.act)))
            |-> |($past(en_rdy) & idx_onehot(q.act)));

    assert_busy_on_new_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel != $past(q.sel)) |-> !sw_ready);

    assert_single_gate_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.ack_s2));
endmodule

// File: rtl/sysclk_switch_gate.sv
`timescale 1ns/1ps
module sysclk_switch_gate (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic ack,
    output logic gclk
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t d, q;
    logic  gate_q;

    always_comb begin
        d.s1 = req;
        d.s2 = q.s1;
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // gate changes only while src_clk is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= q.s2;
    end

    assign ack  = gate_q;
    assign gclk = src_clk & gate_q;
endmodule

// File: rtl/sysclk_switch_prescale.sv
`timescale 1ns/1ps
module sysclk_switch_prescale #(
    parameter int PW = 3
) (
    input  logic          mux_clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pre_in,
    output logic          sys_clk
);
    localparam int CW = (1 << PW) - 1;

    typedef struct packed {
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
        logic [PW-1:0] n;
        logic [CW-1:0] cnt;
        logic          out;
        logic          byp;
    } div_t;

    div_t d, q;
    logic [CW-1:0] last;
    logic          wrap;

    always_comb begin
        d    = q;
        last = CW'((32'd1 << q.n) - 32'd1);
        wrap = (q.cnt == last);
        d.s1 = pre_in;
        d.s2 = q.s1;
        if (wrap) begin
            d.n   = q.s2;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
        d.byp = (d.n == '0);
        d.out = (d.n != '0) && (d.cnt < CW'((32'd1 << d.n) >> 1));
    end

    always_ff @(posedge mux_clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.byp <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sys_clk = q.byp ? mux_clk : q.out;

    assert_pre_at_boundary_R6: assert property (@(posedge mux_clk) disable iff (!rst_n)
        (q.n != $past(q.n)) |-> $past(wrap));
endmodule

// File: rtl/sysclk_switch_crypto.sv
`timescale 1ns/1ps
module sysclk_switch_crypto (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic cdiv_in,
    output logic crypto_clk
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic mode;
        logic half;
    } cry_t;

    cry_t d, q;

    always_comb begin
        d      = q;
        d.s1   = cdiv_in;
        d.s2   = q.s1;
        d.half = ~q.half;
        // only switch mode on the edge where the halved clock rises
        if (!q.half) d.mode = q.s2;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign crypto_clk = q.mode ? q.half : sys_clk;

    assert_mode_on_rise_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (q.mode != $past(q.mode)) |-> $past(!q.half));
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
    import sysclk_switch_pkg::*;
(
    input  logic            ctl_clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic [NSRC-1:0] osc_rdy,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_src,
    input  logic [PREW-1:0] cfg_prescale,
    input  logic            cfg_cdiv,
    input  logic [NSRC-1:0] cfg_osc_en,
    output logic [SELW-1:0] sel_code,
    output logic [PREW-1:0] prescale,
    output logic            cdiv,
    output logic [NSRC-1:0] osc_en,
    output logic [NSRC-1:0] osc_rdy_stat,
    output logic            sw_ready,
    output logic            sys_clk,
    output logic            crypto_clk
);
    logic [NSRC-1:0] req, ack, gclk;
    logic            mux_clk;

    sysclk_switch_ctrl u_ctrl (
        .clk      (ctl_clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_src  (cfg_src),
        .cfg_pre  (cfg_prescale),
        .cfg_cdiv (cfg_cdiv),
        .cfg_en   (cfg_osc_en),
        .osc_rdy  (osc_rdy),
        .gate_ack (ack),
        .sel_code (sel_code),
        .pre      (prescale),
        .cdiv     (cdiv),
        .en       (osc_en),
        .rdy_stat (osc_rdy_stat),
        .sw_ready (sw_ready),
        .gate_req (req)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        sysclk_switch_gate u_gate (
            .src_clk (src_clk[g]),
            .rst_n   (rst_n),
            .req     (req[g]),
            .ack     (ack[g]),
            .gclk    (gclk[g])
        );
    end

    assign mux_clk = |gclk;

    sysclk_switch_prescale #(.PW(PREW)) u_pre (
        .mux_clk (mux_clk),
        .rst_n   (rst_n),
        .pre_in  (prescale),
        .sys_clk (sys_clk)
    );

    sysclk_switch_crypto u_cry (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .cdiv_in    (cdiv),
        .crypto_clk (crypto_clk)
    );
endmodule

// File: tb/sysclk_switch_tb_top.sv
`timescale 1ns/1ps
module sysclk_switch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       c0 = 0, c1 = 0, c2 = 0, c3 = 0, c4 = 0, c5 = 0;
    logic [5:0] src_clk;
    logic [5:0] osc_rdy = '0;
    logic       cfg_we = 0;
    logic [2:0] cfg_src = '0;
    logic [2:0] cfg_prescale = '0;
    logic       cfg_cdiv = 0;
    logic [5:0] cfg_osc_en = 6'b000001;
    logic [2:0] sel_code, prescale;
    logic       cdiv, sw_ready, sys_clk, crypto_clk;
    logic [5:0] osc_en, osc_rdy_stat;

    always #4.0  clk = ~clk;
    always #5.0  c0 = ~c0;
    always #7.0  c1 = ~c1;
    always #9.0  c2 = ~c2;
    always #6.0  c3 = ~c3;
    always #11.0 c4 = ~c4;
    always #13.0 c5 = ~c5;
    assign src_clk = {c5, c4, c3, c2, c1, c0};

    sysclk_switch dut_i (
        .ctl_clk(clk), .rst_n(rst_n), .src_clk(src_clk), .osc_rdy(osc_rdy),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_prescale(cfg_prescale),
        .cfg_cdiv(cfg_cdiv), .cfg_osc_en(cfg_osc_en), .sel_code(sel_code),
        .prescale(prescale), .cdiv(cdiv), .osc_en(osc_en),
        .osc_rdy_stat(osc_rdy_stat), .sw_ready(sw_ready),
        .sys_clk(sys_clk), .crypto_clk(crypto_clk)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit near(input realtime a, input realtime b);
        return (a > b - 0.01) && (a < b + 0.01);
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [2:0] m_sel = '0, m_pre = '0;
    logic       m_cdiv = 0;
    logic [5:0] m_en = 6'b000001, m_r1 = '0, m_r2 = '0;
    bit         m_live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel <= '0; m_pre <= '0; m_cdiv <= 0; m_en <= 6'b000001;
            m_r1 <= '0; m_r2 <= '0;
        end else begin
            if (cfg_we) begin
                if (cfg_src != 3'd1 && cfg_src != 3'd7) m_sel <= cfg_src;
                m_pre <= cfg_prescale; m_cdiv <= cfg_cdiv; m_en <= cfg_osc_en;
            end
            m_r1 <= osc_rdy;
            m_r2 <= m_r1;
        end
        m_live <= 1;
    end

    always @(negedge clk) begin
        if (m_live && !done) begin
            chk(sel_code == m_sel, "R2", "sel_code", sel_code, m_sel);
            chk(prescale == m_pre, "R1", "prescale", prescale, m_pre);
            chk(cdiv == m_cdiv, "R1", "cdiv", cdiv, m_cdiv);
            chk(osc_en == m_en, "R1", "osc_en", osc_en, m_en);
            chk(osc_rdy_stat == m_r2, "R8", "osc_rdy_stat", osc_rdy_stat, m_r2);
        end
    end

    // ---------------- phase monitors ----------------
    realtime sys_last = 0, cry_last = 0, win_t = 1.0;
    bit      mon_on = 0, win_on = 0;
    int      sys_pos = 0, win_new = 0;

    always @(posedge sys_clk) sys_pos++;

    always @(sys_clk) begin
        realtime ph;
        ph = $realtime - sys_last;
        if (mon_on && !done) begin
            chk(ph > 4.99, "R9", "sys_clk phase ps", longint'($rtoi(ph * 1000)), 5000);
            if (win_on) begin
                chk(near(ph, win_t / 2) || near(ph, 64 * win_t), "R6", "phase ps",
                    longint'($rtoi(ph * 1000)), longint'($rtoi(win_t * 500)));
                if (near(ph, win_t / 2)) win_new++;
            end
        end
        sys_last = $realtime;
    end

    always @(crypto_clk) begin
        realtime ph;
        ph = $realtime - cry_last;
        if (mon_on && !done)
            chk(ph > 4.99, "R9", "crypto_clk phase ps", longint'($rtoi(ph * 1000)), 5000);
        cry_last = $realtime;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] s, input logic [2:0] p,
                      input logic cd, input logic [5:0] e);
        @(posedge clk); #1;
        cfg_we = 1; cfg_src = s; cfg_prescale = p; cfg_cdiv = cd; cfg_osc_en = e;
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic set_rdy(input logic [5:0] v);
        @(posedge clk); #1;
        osc_rdy = v;
    endtask

    task automatic wait_ready(input string req);
        int k = 0;
        while (!sw_ready && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk(sw_ready, req, "sw_ready within bound", sw_ready, 1);
    endtask

    task automatic sys_period(input realtime exp, input string req);
        realtime t0;
        @(posedge sys_clk); t0 = $realtime;
        @(posedge sys_clk);
        chk(near($realtime - t0, exp), req, "sys_clk period ps",
            longint'($rtoi(($realtime - t0) * 1000)), longint'($rtoi(exp * 1000)));
    endtask

    task automatic cry_period(input realtime exp, input string req);
        realtime t0;
        @(posedge crypto_clk); t0 = $realtime;
        @(posedge crypto_clk);
        chk(near($realtime - t0, exp), req, "crypto_clk period ps",
            longint'($rtoi(($realtime - t0) * 1000)), longint'($rtoi(exp * 1000)));
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int snap;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(sel_code == 3'd0, "R1", "sel_code in reset", sel_code, 0);
        chk(prescale == 3'd0, "R1", "prescale in reset", prescale, 0);
        chk(osc_en == 6'b000001, "R1", "osc_en in reset", osc_en, 1);
        chk(!sw_ready, "R1", "sw_ready in reset", sw_ready, 0);
        @(posedge clk); #1 rst_n = 1;

        // R1/R3: source 0 not ready, no clock
        snap = sys_pos;
        repeat (50) @(negedge clk);
        chk(sys_pos == snap, "R3", "sys_clk edges while not ready", sys_pos - snap, 0);
        chk(!sw_ready, "R3", "sw_ready while not ready", sw_ready, 0);

        set_rdy(6'h3F);
        wait_ready("R4");
        repeat (10) @(negedge clk);
        @(posedge sys_clk); mon_on = 1;
        sys_period(10.0, "R5");

        // R2: unassigned codes ignored, other fields loaded
        wr(3'd1, 3'd1, 0, 6'b000001);
        @(negedge clk);
        chk(sel_code == 3'd0, "R2", "code 1 ignored", sel_code, 0);
        chk(prescale == 3'd1, "R2", "prescale loaded with code 1", prescale, 1);
        repeat (40) @(negedge clk);
        sys_period(20.0, "R5");
        wr(3'd7, 3'd1, 0, 6'b000001);
        @(negedge clk);
        chk(sel_code == 3'd0, "R2", "code 7 ignored", sel_code, 0);
        chk(sw_ready, "R2", "ready kept after code 7", sw_ready, 1);

        // R3: target disabled
        wr(3'd4, 3'd1, 0, 6'b000001);
        @(negedge clk);
        chk(!sw_ready, "R4", "busy after new code", sw_ready, 0);
        repeat (100) @(negedge clk);
        chk(!sw_ready, "R3", "disabled target blocks", sw_ready, 0);
        sys_period(20.0, "R3");
        wr(3'd4, 3'd1, 0, 6'b001001);
        wait_ready("R4");
        repeat (20) @(negedge clk);
        sys_period(24.0, "R5");

        // R3: target not ready
        set_rdy(6'h1F);
        wr(3'd6, 3'd1, 0, 6'b101001);
        @(negedge clk);
        chk(!sw_ready, "R4", "busy after new code", sw_ready, 0);
        repeat (100) @(negedge clk);
        chk(!sw_ready, "R3", "unready target blocks", sw_ready, 0);
        sys_period(24.0, "R3");
        set_rdy(6'h3F);
        wait_ready("R4");
        repeat (20) @(negedge clk);
        sys_period(52.0, "R5");

        // R6: prescale change only at period boundary
        wr(3'd6, 3'd7, 0, 6'b101001);
        repeat (600) @(negedge clk);
        sys_period(3328.0, "R5");
        @(posedge sys_clk);
        win_t = 26.0; win_new = 0; win_on = 1;
        wr(3'd6, 3'd0, 0, 6'b101001);
        repeat (600) @(negedge clk);
        win_on = 0;
        chk(win_new > 0, "R6", "new phase length seen", win_new, 1);
        sys_period(26.0, "R5");

        // R7: crypto clock modes
        wr(3'd6, 3'd0, 1, 6'b101001);
        repeat (30) @(negedge clk);
        cry_period(52.0, "R7");
        wr(3'd6, 3'd0, 0, 6'b101001);
        repeat (30) @(negedge clk);
        cry_period(26.0, "R7");

        // R5/R9: switch tour across sources
        wr(3'd3, 3'd0, 0, 6'h3F);
        wait_ready("R4");
        repeat (20) @(negedge clk);
        sys_period(18.0, "R5");
        wr(3'd5, 3'd0, 1, 6'h3F);
        wait_ready("R4");
        repeat (30) @(negedge clk);
        sys_period(22.0, "R5");
        cry_period(44.0, "R7");
        wr(3'd2, 3'd2, 0, 6'h3F);
        wait_ready("R4");
        repeat (30) @(negedge clk);
        sys_period(56.0, "R5");
        wr(3'd0, 3'd0, 0, 6'h3F);
        wait_ready("R9");
        repeat (20) @(negedge clk);
        sys_period(10.0, "R5");

        // R8: ready status follows inputs two edges later
        set_rdy(6'b101011);
        repeat (3) @(negedge clk);
        chk(osc_rdy_stat == 6'b101011, "R8", "rdy status", osc_rdy_stat, 6'b101011);
        set_rdy(6'b010101);
        repeat (3) @(negedge clk);
        chk(osc_rdy_stat == 6'b010101, "R8", "rdy status", osc_rdy_stat, 6'b010101);
        set_rdy(6'h3F);
        repeat (5) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end
endmodule